// File: doc/BRIEF.md
# CRC-Protected SPI Command Target

This block is the serial control port of an eight-channel sensing front end. A host addresses it over a four-wire SPI link in 24-bit frames. Each host frame holds a write or read command followed by a 5-bit checksum, and the block executes the command only when that checksum is correct. Every frame the block sends back carries the eight sensed inputs, a second byte, three supply and wire status bits, and a checksum of its own. The host can therefore detect corruption in either direction.

The SPI pins are sampled through synchronizers into a single system clock domain. A static mode input selects one of two modes. In immediate mode the command is decoded while it arrives and the answer is shifted out in the same frame. In chained mode the port acts as a 24-bit shift register, so several targets can share one select line; each frame then returns the answer to the previous command. A corrupted command is dropped and latches a sticky checksum fault. This fault can drive an active-low fault pin.

Top module: `spi_crc_target`

## Requirements
- R1: The checksum of a 19-bit payload is the 5-bit remainder of the 24-bit word {payload, 5'b00111}, processed MSB first and divided by x^5+x^4+x^2+1. Host frames carry it in bits [4:0] over bits [23:5]. Every response frame carries it in bits [4:0] over its own bits [23:5], so an all-zero response payload gives 24'h000007.
- R2: A host frame with bit 23 = 1 is a write: bits [22:16] are the address, bits [15:8] the data, and bits [7:5] are don't-care. A read has bit 23 = 0 and bits [22:16] as the address. A write with a correct checksum updates the addressed register when the select line is released.
- R3: A frame with a wrong checksum changes no register and sets the checksum fault flag. The flag reads back as bit 0 of address 0x01.
- R4: The fault flag stays set until a frame with a correct checksum completes, whether that frame is a read or a write. That frame clears it.
- R5: fault_n is low exactly when the fault flag is set and bit 0 of the enable register at address 0x02 is 1.
- R6: In immediate mode, the response to a write-format frame is [23:16] sense_in, [15:8] open_wire, [7] vsup_low, [6] vsup_lost, [5] OR of open_wire, and [4:0] the checksum. The inputs are captured when the select line falls.
- R7: In immediate mode, a read-format frame returns, in bits [15:8], the addressed register value as it was before the frame. The register map is: 0x01 fault (read-only), 0x02 enable, 0x03 and 0x04 configuration. All other addresses read 0 and ignore writes.
- R8: In chained mode, frame N+1 shifts out the response to frame N. That response uses the R6 layout with the inputs captured when frame N ends. Byte [15:8] is the register value only for a read with a correct checksum; otherwise it is open_wire.
- R9: In chained mode, clocks beyond the 24th shift out the SDI bits received 24 clocks earlier.
- R10: A frame without exactly 24 clocks changes no register, leaves the fault flag unchanged, and leaves the pending chained response unchanged.
- R11: SDI is sampled on the rising SCLK edge, and SDO changes after the falling edge, MSB first. SDO is low while cs_n is high.
- R12: After reset, all registers are 0, the flag is clear, fault_n is high, and the first chained response is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| chain_mode | input | 1 | 0 = immediate response, 1 = chained shift mode (static) |
| sclk | input | 1 | SPI serial clock, idles low |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host or to the next target |
| sense_in | input | 8 | Sensed input states reported in each response |
| open_wire | input | 8 | Per-channel wire-break indications |
| vsup_low | input | 1 | Field supply low status |
| vsup_lost | input | 1 | Field supply missing status |
| fault_n | output | 1 | Active-low checksum fault indication |

## Verification
The bench targets several corner cases. One is the mid-frame substitution of the register byte in immediate mode: a design that decodes the address one clock late would send the wire-break byte, or a shifted value, with a checksum over the wrong payload. Another is a bad checksum followed by short and long frames. A design that counts loosely would clear the sticky flag, or commit the write, on a 16- or 25-clock frame. A read of the fault register must show the flag set even though that same read clears it, which catches a design that updates state before it answers. In chained mode the bench checks the one-frame lag, the zero response after reset, and the 24-clock pass-through. These catch a design that reloads the shift register too early or forwards the wrong bit.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;

    localparam int FRAME_W = 24;
    localparam int CRC_W   = 5;
    localparam int PAY_W   = FRAME_W - CRC_W;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 8;
    localparam int STAT_W  = 3;
    localparam int HDR_W   = 1 + ADDR_W;
    localparam int CNT_MAX = FRAME_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    localparam logic [CRC_W:0]   CRC_POLY = 6'h35;
    localparam logic [CRC_W-1:0] CRC_SEED = 5'h07;

    // Remainder of {payload, seed} over the generator, MSB first.
    function automatic logic [CRC_W-1:0] crc5_calc(input logic [PAY_W-1:0] pay);
        logic [FRAME_W-1:0] word;
        logic [CRC_W:0]     acc;
        word = {pay, CRC_SEED};
        acc  = word[FRAME_W-1 -: CRC_W+1];
        if (acc[CRC_W]) acc = acc ^ CRC_POLY;
        for (int i = FRAME_W - CRC_W - 2; i >= 0; i--) begin
            acc = {acc[CRC_W-1:0], word[i]};
            if (acc[CRC_W]) acc = acc ^ CRC_POLY;
        end
        return acc[CRC_W-1:0];
    endfunction

    // Response frame: inputs, second byte, status, checksum.
    function automatic logic [FRAME_W-1:0] build_resp(
        input logic [DATA_W-1:0] din,
        input logic [DATA_W-1:0] second,
        input logic [STAT_W-1:0] stat
    );
        logic [PAY_W-1:0] pay;
        pay = {din, second, stat};
        return {pay, crc5_calc(pay)};
    endfunction

    typedef struct packed {
        logic [FRAME_W-1:0] rx;
        logic [FRAME_W-1:0] sh;
        logic [FRAME_W-1:0] pend;
        logic [CNT_W-1:0]   cnt;
        logic               in_bit;
        logic [DATA_W-1:0]  snap_in;
        logic [DATA_W-1:0]  snap_wb;
        logic [STAT_W-1:0]  snap_st;
    } eng_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    output logic sdi_s,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic cs_start,
    output logic cs_end
);

    typedef struct packed {
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] csn;
        logic [STAGES-1:0] dat;
        logic              sck_prev;
        logic              act_prev;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  sck_s;

    always_comb begin
        sync_d          = sync_q;
        sync_d.sck      = {sync_q.sck[STAGES-2:0], sclk};
        sync_d.csn      = {sync_q.csn[STAGES-2:0], cs_n};
        sync_d.dat      = {sync_q.dat[STAGES-2:0], sdi};
        sync_d.sck_prev = sync_q.sck[STAGES-1];
        sync_d.act_prev = !sync_q.csn[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q     <= '0;
            sync_q.csn <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sck_s     = sync_q.sck[STAGES-1];
    assign sdi_s     = sync_q.dat[STAGES-1];
    assign sclk_rise = sck_s && !sync_q.sck_prev;
    assign sclk_fall = !sck_s && sync_q.sck_prev;
    assign cs_act    = !sync_q.csn[STAGES-1];
    assign cs_start  = cs_act && !sync_q.act_prev;
    assign cs_end    = !cs_act && sync_q.act_prev;

endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_crc_pkg::*;
#(
    parameter int NUM_CFG    = 2,
    parameter int FAULT_ADDR = 1,
    parameter int FEN_ADDR   = 2,
    parameter int CFG_BASE   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic              crc_ok,
    input  logic              cmd_wr,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              fault_n
);

    localparam logic [ADDR_W-1:0] A_FAULT = ADDR_W'(FAULT_ADDR);
    localparam logic [ADDR_W-1:0] A_FEN   = ADDR_W'(FEN_ADDR);

    typedef struct packed {
        logic                            flag;
        logic [DATA_W-1:0]               fen;
        logic [NUM_CFG-1:0][DATA_W-1:0]  cfg;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [NUM_CFG-1:0] wr_hit;
    logic [NUM_CFG-1:0] rd_hit;

    genvar g;
    generate
        for (g = 0; g < NUM_CFG; g++) begin : g_cfg_dec
            assign wr_hit[g] = (cmd_addr == ADDR_W'(CFG_BASE + g));
            assign rd_hit[g] = (rd_addr == ADDR_W'(CFG_BASE + g));
        end
    endgenerate

    always_comb begin
        regs_d = regs_q;
        if (frame_done) begin
            regs_d.flag = !crc_ok;
            if (crc_ok && cmd_wr) begin
                if (cmd_addr == A_FEN) regs_d.fen = cmd_data;
                for (int i = 0; i < NUM_CFG; i++) begin
                    if (wr_hit[i]) regs_d.cfg[i] = cmd_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_FAULT) rd_data = {{(DATA_W-1){1'b0}}, regs_q.flag};
        if (rd_addr == A_FEN)   rd_data = regs_q.fen;
        for (int i = 0; i < NUM_CFG; i++) begin
            if (rd_hit[i]) rd_data = regs_q.cfg[i];
        end
    end

    assign fault_n = !(regs_q.flag && regs_q.fen[0]);

    // R3: a rejected frame latches the flag and leaves the registers alone
    p_bad_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && !crc_ok |=> regs_q.flag);
    p_bad_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && !crc_ok |=> $stable(regs_q.cfg) && $stable(regs_q.fen));
    // R4: only a good complete frame clears the flag; otherwise it holds
    p_good_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && crc_ok |=> !regs_q.flag);
    p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(regs_q.flag));

endmodule

// File: rtl/spi_crc_target.sv
module spi_crc_target
    import spi_crc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NUM_CFG     = 2,
    parameter int FAULT_ADDR  = 1,
    parameter int FEN_ADDR    = 2,
    parameter int CFG_BASE    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chain_mode,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              sdi,
    output logic              sdo,
    input  logic [DATA_W-1:0] sense_in,
    input  logic [DATA_W-1:0] open_wire,
    input  logic              vsup_low,
    input  logic              vsup_lost,
    output logic              fault_n
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CNT_MAX);
    localparam int               TAIL_W   = FRAME_W - HDR_W;

    logic sdi_s, sclk_rise, sclk_fall, cs_act, cs_start, cs_end;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sdi       (sdi),
        .sdi_s     (sdi_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_act    (cs_act),
        .cs_start  (cs_start),
        .cs_end    (cs_end)
    );

    eng_t eng_d, eng_q;

    logic [FRAME_W-1:0] rx_next;
    logic               frame_done;
    logic               crc_ok;
    logic               cmd_wr;
    logic [ADDR_W-1:0]  cmd_addr;
    logic [DATA_W-1:0]  cmd_data;
    logic [ADDR_W-1:0]  rd_addr;
    logic [DATA_W-1:0]  rd_data;
    logic [STAT_W-1:0]  live_st;
    logic [FRAME_W-1:0] patch;

    assign rx_next    = {eng_q.rx[FRAME_W-2:0], sdi_s};
    assign frame_done = cs_end && (eng_q.cnt == CNT_FULL);
    assign cmd_wr     = eng_q.rx[FRAME_W-1];
    assign cmd_addr   = eng_q.rx[FRAME_W-2 -: ADDR_W];
    assign cmd_data   = eng_q.rx[FRAME_W-HDR_W-1 -: DATA_W];
    assign crc_ok     = (crc5_calc(eng_q.rx[FRAME_W-1:CRC_W]) == eng_q.rx[CRC_W-1:0]);
    assign rd_addr    = cs_end ? cmd_addr : rx_next[ADDR_W-1:0];
    assign live_st    = {vsup_low, vsup_lost, |open_wire};
    assign patch      = build_resp(eng_q.snap_in,
                                   rx_next[HDR_W-1] ? eng_q.snap_wb : rd_data,
                                   eng_q.snap_st);

    spi_cmd_regs #(
        .NUM_CFG    (NUM_CFG),
        .FAULT_ADDR (FAULT_ADDR),
        .FEN_ADDR   (FEN_ADDR),
        .CFG_BASE   (CFG_BASE)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .crc_ok     (crc_ok),
        .cmd_wr     (cmd_wr),
        .cmd_addr   (cmd_addr),
        .cmd_data   (cmd_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .fault_n    (fault_n)
    );

    always_comb begin
        eng_d = eng_q;
        if (cs_start) begin
            eng_d.cnt     = '0;
            eng_d.snap_in = sense_in;
            eng_d.snap_wb = open_wire;
            eng_d.snap_st = live_st;
            if (chain_mode) eng_d.sh = eng_q.pend;
            else            eng_d.sh = build_resp(sense_in, open_wire, live_st);
        end else if (cs_act) begin
            if (sclk_rise) begin
                eng_d.rx     = rx_next;
                eng_d.in_bit = sdi_s;
                if (eng_q.cnt != CNT_SAT) eng_d.cnt = eng_q.cnt + 1'b1;
                // Header complete: swap in the answer for the rest of the frame.
                if (!chain_mode && eng_q.cnt == CNT_HDR) begin
                    eng_d.sh[FRAME_W-2 -: TAIL_W] = patch[TAIL_W-1:0];
                end
            end
            if (sclk_fall) begin
                eng_d.sh = {eng_q.sh[FRAME_W-2:0], eng_q.in_bit};
            end
        end
        if (frame_done && chain_mode) begin
            eng_d.pend = build_resp(sense_in,
                                    (!cmd_wr && crc_ok) ? rd_data : open_wire,
                                    live_st);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign sdo = cs_act && eng_q.sh[FRAME_W-1];

    // R11: no bit is taken in while the frame is not selected
    p_rx_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act && !cs_end |=> $stable(eng_q.rx));
    // R10: an incomplete or overlong frame leaves the chained answer alone
    p_pend_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_end && eng_q.cnt != CNT_FULL |=> $stable(eng_q.pend));

endmodule

// File: tb/spi_crc_target_test.sv
module spi_crc_target_test;

    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chain_mode = 1'b0;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       sdi = 1'b0;
    logic [7:0] sense_in = '0;
    logic [7:0] open_wire = '0;
    logic       vsup_low = 1'b0;
    logic       vsup_lost = 1'b0;
    logic       sdo;
    logic       fault_n;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    logic        m_flag;
    logic [7:0]  m_fen;
    logic [7:0]  m_cfg [2];
    logic [23:0] m_pend;

    always #5 clk = ~clk;

    spi_crc_target uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .chain_mode (chain_mode),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .sdi        (sdi),
        .sdo        (sdo),
        .sense_in   (sense_in),
        .open_wire  (open_wire),
        .vsup_low   (vsup_low),
        .vsup_lost  (vsup_lost),
        .fault_n    (fault_n)
    );

    function automatic logic [4:0] crc_ref(input logic [18:0] p);
        logic [23:0] v;
        v = {p, 5'b00111};
        for (int i = 23; i >= 5; i--) begin
            if (v[i]) v = v ^ (24'h35 << (i - 5));
        end
        return v[4:0];
    endfunction

    function automatic logic [7:0] reg_val(input logic [6:0] a);
        case (a)
            7'h01:   return {7'b0, m_flag};
            7'h02:   return m_fen;
            7'h03:   return m_cfg[0];
            7'h04:   return m_cfg[1];
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [23:0] mk_resp(input logic [7:0] second);
        logic [18:0] p;
        p = {sense_in, second, vsup_low, vsup_lost, |open_wire};
        return {p, crc_ref(p)};
    endfunction

    function automatic logic [23:0] mk_cmd(input logic rw, input logic [6:0] a,
                                           input logic [7:0] d, input logic [4:0] flip);
        logic [18:0] p;
        p = rw ? {1'b1, a, d, 3'b000} : {1'b0, a, 11'b0};
        return {p, crc_ref(p) ^ flip};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic spi_xfer(input logic [47:0] bits, input int n, output logic [47:0] cap);
        cap  = '0;
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int k = 0; k < n; k++) begin
            cap[47-k] = sdo;
            sdi = bits[47-k];
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
            wait_clk(HALF);
        end
        cs_n = 1'b1;
        sdi  = 1'b0;
        wait_clk(12);
    endtask

    task automatic model_apply(input logic [23:0] cmd);
        if (cmd[4:0] == crc_ref(cmd[23:5])) begin
            m_flag = 1'b0;
            if (cmd[23]) begin
                case (cmd[22:16])
                    7'h02: m_fen = cmd[15:8];
                    7'h03: m_cfg[0] = cmd[15:8];
                    7'h04: m_cfg[1] = cmd[15:8];
                    default: ;
                endcase
            end
        end else begin
            m_flag = 1'b1;
        end
    endtask

    task automatic post_checks();
        check("R5 fault pin", 48'(fault_n), 48'(!(m_flag && m_fen[0])));
        check("R11 sdo idle", 48'(sdo), 48'h0);
    endtask

    task automatic imm_frame(input logic rw, input logic [6:0] a, input logic [7:0] d,
                             input logic [4:0] flip, input string tag);
        logic [23:0] cmd, exp;
        logic [47:0] cap;
        cmd = mk_cmd(rw, a, d, flip);
        exp = mk_resp(rw ? open_wire : reg_val(a));
        spi_xfer({cmd, 24'h0}, 24, cap);
        check(tag, cap[47:24], 48'(exp));
        model_apply(cmd);
        post_checks();
    endtask

    task automatic chain_frame(input logic rw, input logic [6:0] a, input logic [7:0] d,
                               input logic [4:0] flip, input string tag);
        logic [23:0] cmd;
        logic [47:0] cap;
        logic        ok;
        cmd = mk_cmd(rw, a, d, flip);
        spi_xfer({cmd, 24'h0}, 24, cap);
        check(tag, cap[47:24], 48'(m_pend));
        ok = (flip == 5'd0);
        m_pend = mk_resp((!rw && ok) ? reg_val(a) : open_wire);
        model_apply(cmd);
        post_checks();
    endtask

    task automatic rand_inputs();
        sense_in  = 8'($urandom);
        open_wire = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
        vsup_low  = 1'($urandom);
        vsup_lost = 1'($urandom);
    endtask

    function automatic logic [6:0] rand_addr();
        return ($urandom % 8 == 0) ? 7'($urandom) : 7'($urandom % 6);
    endfunction

    function automatic logic [4:0] rand_flip();
        return ($urandom % 5 == 0) ? 5'(1 + $urandom % 31) : 5'd0;
    endfunction

    task automatic do_reset(input logic mode);
        rst_n = 1'b0;
        chain_mode = mode;
        cs_n = 1'b1;
        sclk = 1'b0;
        sdi = 1'b0;
        sense_in = '0;
        open_wire = '0;
        vsup_low = 1'b0;
        vsup_lost = 1'b0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        m_flag = 1'b0;
        m_fen = '0;
        m_cfg[0] = '0;
        m_cfg[1] = '0;
        m_pend = '0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [47:0] cap;
        logic [23:0] cmd;
        logic [23:0] fwd;
        void'($urandom(32'd20240611));

        // R12: reset state
        do_reset(1'b0);
        check("R12 fault_n after reset", 48'(fault_n), 48'h1);
        check("R11 sdo idle after reset", 48'(sdo), 48'h0);

        // R1: all-zero payload gives the seed as its checksum
        spi_xfer({mk_cmd(1'b0, 7'h03, 8'h00, 5'd0), 24'h0}, 24, cap);
        check("R1 zero payload checksum", cap[47:24], 48'h000007);
        post_checks();

        imm_frame(1'b0, 7'h02, 8'h00, 5'd0, "R12 enable reg zero");
        imm_frame(1'b0, 7'h04, 8'h00, 5'd0, "R12 cfg reg zero");

        // R2 / R6 / R7: write then read back
        rand_inputs();
        imm_frame(1'b1, 7'h03, 8'hA5, 5'd0, "R6 write response");
        imm_frame(1'b0, 7'h03, 8'h00, 5'd0, "R2 R7 cfg readback");
        imm_frame(1'b1, 7'h10, 8'hFF, 5'd0, "R7 unmapped write");
        imm_frame(1'b0, 7'h10, 8'h00, 5'd0, "R7 unmapped reads zero");
        imm_frame(1'b1, 7'h01, 8'hFF, 5'd0, "R7 fault reg write");
        imm_frame(1'b0, 7'h01, 8'h00, 5'd0, "R7 fault reg read-only");
        imm_frame(1'b1, 7'h02, 8'h01, 5'd0, "R2 enable write");

        // R3 / R5 / R10 / R4: bad frames, odd lengths, then recovery
        imm_frame(1'b1, 7'h03, 8'h3C, 5'h04, "R3 bad write");
        imm_frame(1'b0, 7'h04, 8'h00, 5'h11, "R3 bad read");
        cmd = mk_cmd(1'b1, 7'h04, 8'h77, 5'd0);
        spi_xfer({cmd, 24'h0}, 16, cap);
        post_checks();
        spi_xfer({cmd, 24'h0}, 25, cap);
        post_checks();
        imm_frame(1'b0, 7'h01, 8'h00, 5'd0, "R3 R10 flag still set");
        check("R4 flag cleared by good read", 48'(fault_n), 48'h1);
        imm_frame(1'b0, 7'h03, 8'h00, 5'd0, "R3 cfg kept");
        imm_frame(1'b0, 7'h04, 8'h00, 5'd0, "R10 cfg untouched");
        imm_frame(1'b1, 7'h02, 8'h00, 5'd0, "R5 disable");
        imm_frame(1'b1, 7'h03, 8'h99, 5'h1F, "R5 bad with pin masked");
        imm_frame(1'b0, 7'h01, 8'h00, 5'd0, "R4 masked flag readable");

        // Random immediate traffic
        for (int i = 0; i < 110; i++) begin
            logic rw;
            rand_inputs();
            rw = 1'($urandom);
            imm_frame(rw, rand_addr(), 8'($urandom), rand_flip(),
                      rw ? "R6 random write" : "R7 random read");
        end

        // Chained mode
        do_reset(1'b1);
        chain_frame(1'b1, 7'h02, 8'h01, 5'd0, "R12 first chained response");
        chain_frame(1'b1, 7'h04, 8'h5A, 5'd0, "R8 write answer");
        rand_inputs();
        chain_frame(1'b0, 7'h04, 8'h00, 5'd0, "R8 lag one frame");
        chain_frame(1'b0, 7'h04, 8'h00, 5'h02, "R8 read answer");
        chain_frame(1'b0, 7'h03, 8'h00, 5'd0, "R8 bad read answer");

        // R9: pass-through of extra clocks; R10: pending kept
        fwd = 24'($urandom);
        spi_xfer({fwd, 24'($urandom)}, 48, cap);
        check("R9 pending before pass-through", cap[47:24], 48'(m_pend));
        check("R9 pass-through data", cap[23:0], 48'(fwd));
        post_checks();
        chain_frame(1'b1, 7'h03, 8'h11, 5'd0, "R10 pending kept");

        for (int i = 0; i < 70; i++) begin
            chain_frame(1'($urandom), rand_addr(), 8'($urandom), rand_flip(),
                        "R8 random chained");
            rand_inputs();
        end

        finish_run();
    end

endmodule